// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block is a synthesizable behavioural model of a synchronous static RAM. Words are 36 bits wide, split into four 9-bit byte lanes. All address, control and write-data inputs are sampled on the rising clock edge. A cycle is started by one of two address strobes. Later beats of a four-word burst are produced internally, so the host only has to pulse an advance input. Reads pass through an input register and an output register before they reach the data port. Writes are committed one edge after they are sampled.

Three chip-select inputs must agree before an access is accepted. A host-side strobe only counts while the first select is active. Writes can cover all four lanes through a single global control, or selected lanes through a lane-write enable plus one enable bit per lane. The data port is split into an input bus, an output bus and an output-valid flag. An output-enable input gates that flag without waiting for a clock edge. A sleep input parks the block in a low-power state: the stored data is kept, accesses are refused and the outputs are released. Leaving the state takes a fixed recovery interval.

Top module: `sram_burst_core`

## Requirements
- R1: An access starts only if, at the strobe edge, `sel_a_ni`=0, `sel_b_i`=1 and `sel_c_ni`=0. A strobe seen with any other select combination ends any burst in progress. No beat is issued after it until the next selected strobe.
- R2: `cpu_stb_ni` low has no effect while `sel_a_ni` is high. `ctl_stb_ni` low with `sel_a_ni` high deselects the block.
- R3: An access started by `cpu_stb_ni` (with `sel_a_ni` low) is always a read, whatever the write controls say, even if `ctl_stb_ni` is low at the same edge. An access started by `ctl_stb_ni` alone follows the write decode of R4 and R5.
- R4: When `wr_all_ni` is low, the access writes all four lanes, whatever `lane_wr_ni` and `lane_en_ni` are.
- R5: When `wr_all_ni` is high and `lane_wr_ni` is low, lane i (bits 9i+8..9i of `wdata_i`) is written only if `lane_en_ni[i]` is low. If no lane enable is low, or if `lane_wr_ni` is high, the access is a read. Write data is taken at the same edge as the address.
- R6: A read sampled at edge k drives its word on `rdata_o`, with `rdata_oe_o` high, after edge k+1, provided `out_en_ni` is low.
- R7: An edge that issues no read (deselect, write, idle or reset) leaves `rdata_oe_o` low and `rdata_o` zero after the following edge.
- R8: `out_en_ni` high forces `rdata_oe_o` low and `rdata_o` to zero at once, without a clock edge. Lowering it restores the pending read word at once.
- R9: While a burst is active and no strobe is seen, `step_ni` low advances to the next beat. The two low address bits become base+n mod 4 when `linear_i`=1, or base XOR n when `linear_i`=0. The upper bits stay fixed, and the sequence wraps after four beats. Each beat reads or writes according to R4 and R5.
- R10: While a burst is active, no strobe is seen and `step_ni` is high, the current address is accessed again.
- R11: When `sleep_i` is sampled high on two consecutive edges, the block is asleep from the second of those edges. While asleep, `rdata_oe_o` is low, strobes and writes are ignored, stored words are kept and any burst is cancelled.
- R12: The edge that samples `sleep_i` low while the block is asleep, and the two edges after it, still ignore strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Low-power request |
| sel_a_ni | input | 1 | Chip select A, active low; also qualifies the host strobe |
| sel_b_i | input | 1 | Chip select B, active high |
| sel_c_ni | input | 1 | Chip select C, active low |
| cpu_stb_ni | input | 1 | Host-side address strobe (read start), active low |
| ctl_stb_ni | input | 1 | Controller-side address strobe, active low |
| step_ni | input | 1 | Burst advance, active low |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| wr_all_ni | input | 1 | Write all lanes, active low |
| lane_wr_ni | input | 1 | Lane-write enable, active low |
| lane_en_ni | input | 4 | Per-lane write enables, active low |
| addr_i | input | ADDR_W (8) | Word address |
| wdata_i | input | 36 | Write data |
| out_en_ni | input | 1 | Output enable, active low, asynchronous |
| rdata_o | output | 36 | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Read data is being driven |

## Verification
The bench first builds bursts from the controller strobe in both burst orders and with non-zero base offsets, so that wrap-around differs between the two orders. Single accesses then try each write decode: all lanes, two odd lanes, one lane, and the two lane settings that must fall back to a read. Reading these words back separates a wrong lane mask from a missed write. Further patterns cover a host strobe carrying write controls, strobes with each select combination wrong, a held suspend, an output-enable toggle between edges, and writes attempted while asleep and during recovery. A reference model compares every cycle, so an off-by-one-edge latency, an entry or recovery interval of the wrong length, or a write that should have been blocked all show up as a mismatch on the output port.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned WORD_W = LANES * LANE_W;
  localparam int unsigned BEAT_W = 2;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [BEAT_W-1:0] beat_t;

  // low address bits of a burst beat
  function automatic beat_t beat_addr(input beat_t base, input beat_t beat, input logic linear);
    return linear ? beat_t'(base + beat) : (base ^ beat);
  endfunction
endpackage

// File: rtl/sram_pwr_ctl.sv
module sram_pwr_ctl #(
  parameter int unsigned ENTER_CYC = 2,
  parameter int unsigned WAKE_CYC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic asleep_o,
  output logic blocked_o
);
  localparam int unsigned MAX_CYC = (ENTER_CYC > WAKE_CYC) ? ENTER_CYC : WAKE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             asleep_q;
  logic [CNT_W-1:0] ent_cnt_q, wake_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asleep_q   <= 1'b0;
      ent_cnt_q  <= '0;
      wake_cnt_q <= '0;
    end else if (asleep_q) begin
      if (!sleep_i) begin
        asleep_q   <= 1'b0;
        wake_cnt_q <= CNT_W'(WAKE_CYC);
      end
    end else if (wake_cnt_q != '0) begin
      wake_cnt_q <= wake_cnt_q - 1'b1;
    end else if (sleep_i) begin
      if (ent_cnt_q == CNT_W'(ENTER_CYC - 1)) begin
        asleep_q  <= 1'b1;
        ent_cnt_q <= '0;
      end else begin
        ent_cnt_q <= ent_cnt_q + 1'b1;
      end
    end else begin
      ent_cnt_q <= '0;
    end
  end

  assign asleep_o  = asleep_q;
  assign blocked_o = asleep_q || (wake_cnt_q != '0);

  // R11
  enter_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_q) |-> $past(sleep_i));

  // R12
  wake_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asleep_q) |-> blocked_o);
endmodule

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blocked_i,
  input  logic              flush_i,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              sel_c_ni,
  input  logic              cpu_stb_ni,
  input  logic              ctl_stb_ni,
  input  logic              step_ni,
  input  logic              linear_i,
  input  logic              wr_all_ni,
  input  logic              lane_wr_ni,
  input  lane_mask_t        lane_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              issue_o,
  output lane_mask_t        issue_lanes_o,
  output logic [ADDR_W-1:0] issue_addr_o
);
  logic              active_q;
  logic [ADDR_W-1:0] base_q;
  beat_t             beat_q, beat_nx;
  logic              selected, cpu_stb, ctl_stb, start;
  lane_mask_t        wr_lanes;

  assign selected = !sel_a_ni && sel_b_i && !sel_c_ni;
  assign cpu_stb  = !cpu_stb_ni && !sel_a_ni;
  assign ctl_stb  = !ctl_stb_ni;
  assign start    = cpu_stb || ctl_stb;
  assign beat_nx  = step_ni ? beat_q : beat_t'(beat_q + 1'b1);

  always_comb begin
    if (!wr_all_ni)       wr_lanes = '1;
    else if (!lane_wr_ni) wr_lanes = ~lane_en_ni;
    else                  wr_lanes = '0;
  end

  always_comb begin
    issue_o       = 1'b0;
    issue_lanes_o = '0;
    issue_addr_o  = addr_i;
    if (!blocked_i) begin
      if (start) begin
        issue_o       = selected;
        issue_lanes_o = cpu_stb ? '0 : wr_lanes;
      end else if (active_q) begin
        issue_o       = 1'b1;
        issue_lanes_o = wr_lanes;
        issue_addr_o  = {base_q[ADDR_W-1:BEAT_W], beat_addr(base_q[BEAT_W-1:0], beat_nx, linear_i)};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
    end else if (flush_i) begin
      active_q <= 1'b0;
    end else if (!blocked_i) begin
      if (start) begin
        active_q <= selected;
        base_q   <= addr_i;
        beat_q   <= '0;
      end else if (active_q) begin
        beat_q   <= beat_nx;
      end
    end
  end

  // R1
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blocked_i && !ctl_stb_ni && !(!sel_a_ni && sel_b_i && !sel_c_ni)) |=> !active_q);

  // R2
  cpu_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blocked_i && sel_a_ni && ctl_stb_ni && !active_q) |-> !issue_o);

  // R3
  cpu_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_stb_ni && !sel_a_ni) |-> (issue_lanes_o == '0));

  // R9
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blocked_i && !flush_i && active_q && !start && !step_ni) |=>
      (beat_q == beat_t'($past(beat_q) + 1'b1)));
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_burst_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  lane_mask_t        we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i[g]) cells[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (re_i)    rd_q          <= cells[addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram_burst_core.sv
module sram_burst_core
  import sram_burst_pkg::*;
#(
  parameter  int unsigned DEPTH     = 256,
  parameter  int unsigned ENTER_CYC = 2,
  parameter  int unsigned WAKE_CYC  = 2,
  localparam int unsigned ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              sel_c_ni,
  input  logic              cpu_stb_ni,
  input  logic              ctl_stb_ni,
  input  logic              step_ni,
  input  logic              linear_i,
  input  logic              wr_all_ni,
  input  logic              lane_wr_ni,
  input  logic [LANES-1:0]  lane_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              out_en_ni,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  logic              asleep, blocked;
  logic              issue;
  lane_mask_t        issue_lanes;
  logic [ADDR_W-1:0] issue_addr;

  logic              s1_valid_q;
  lane_mask_t        s1_lanes_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [WORD_W-1:0] s1_wdata_q;
  logic              rd_valid_q;

  lane_mask_t        mem_we;
  logic              mem_re;
  logic [WORD_W-1:0] mem_rdata;

  sram_pwr_ctl #(.ENTER_CYC(ENTER_CYC), .WAKE_CYC(WAKE_CYC)) i_pwr (
    .clk_i, .rst_ni, .sleep_i,
    .asleep_o (asleep),
    .blocked_o(blocked)
  );

  sram_cmd_decode #(.ADDR_W(ADDR_W)) i_dec (
    .clk_i, .rst_ni,
    .blocked_i(blocked),
    .flush_i  (asleep),
    .sel_a_ni, .sel_b_i, .sel_c_ni,
    .cpu_stb_ni, .ctl_stb_ni, .step_ni, .linear_i,
    .wr_all_ni, .lane_wr_ni, .lane_en_ni, .addr_i,
    .issue_o      (issue),
    .issue_lanes_o(issue_lanes),
    .issue_addr_o (issue_addr)
  );

  // input register stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_lanes_q <= '0;
      s1_addr_q  <= '0;
      s1_wdata_q <= '0;
    end else begin
      s1_valid_q <= issue;
      s1_lanes_q <= issue_lanes;
      s1_addr_q  <= issue_addr;
      s1_wdata_q <= wdata_i;
    end
  end

  // self-timed write and read; pending op dropped once asleep
  assign mem_we = (s1_valid_q && !asleep) ? s1_lanes_q : '0;
  assign mem_re = s1_valid_q && (s1_lanes_q == '0) && !asleep;

  sram_lane_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_array (
    .clk_i,
    .we_i   (mem_we),
    .re_i   (mem_re),
    .addr_i (s1_addr_q),
    .wdata_i(s1_wdata_q),
    .rdata_o(mem_rdata)
  );

  // output register stage valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_q <= 1'b0;
    else         rd_valid_q <= mem_re;
  end

  assign rdata_oe_o = rd_valid_q && !out_en_ni && !asleep;
  assign rdata_o    = rdata_oe_o ? mem_rdata : '0;

  // R6
  read_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> $past(issue && (issue_lanes == '0), 2));

  // R7
  no_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue |=> ##1 !rdata_oe_o);

  // R11
  sleep_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep |-> (mem_we == '0) && !rdata_oe_o);

  // R12
  wake_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked && !asleep) |-> !issue);
endmodule

// File: tb/test_sram_burst_core.sv
module test_sram_burst_core;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic        cpu_n = 1'b1, ctl_n = 1'b1, step_n = 1'b1, linear = 1'b1;
  logic        wr_all_n = 1'b1, lane_wr_n = 1'b1, oe_n = 1'b0;
  logic [3:0]  lane_en_n = 4'hF;
  logic [7:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rdata_oe;

  always #4 clk = ~clk;

  sram_burst_core i_sram_burst_core (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep),
    .sel_a_ni(sel_a_n), .sel_b_i(sel_b), .sel_c_ni(sel_c_n),
    .cpu_stb_ni(cpu_n), .ctl_stb_ni(ctl_n), .step_ni(step_n), .linear_i(linear),
    .wr_all_ni(wr_all_n), .lane_wr_ni(lane_wr_n), .lane_en_ni(lane_en_n),
    .addr_i(addr), .wdata_i(wdata), .out_en_ni(oe_n),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  int    checks = 0, fails = 0;
  bit    done = 1'b0;
  string cur_req = "R7";

  // reference model state
  logic [35:0] mem_m [DEPTH];
  logic [3:0]  known [DEPTH];
  bit          m_asleep = 0, m_act = 0;
  int          m_ent = 0, m_wake = 0, m_beat = 0;
  logic [7:0]  m_base = '0;
  bit          s1v = 0, s2v = 0;
  logic [3:0]  s1l = '0, s2k = '0;
  logic [7:0]  s1a = '0;
  logic [35:0] s1d = '0, s2d = '0;

  initial for (int i = 0; i < DEPTH; i++) begin mem_m[i] = '0; known[i] = '0; end

  always @(posedge clk) begin : model
    bit         blk, sel, ps, cs, n_v, n_s2v;
    logic [3:0] wl, n_l;
    logic [7:0] n_a;
    logic [1:0] lo;
    if (!rst_n) begin
      m_asleep = 0; m_act = 0; m_ent = 0; m_wake = 0; m_beat = 0; m_base = '0;
      s1v = 0; s2v = 0; s1l = '0; s1a = '0; s1d = '0;
    end else begin
      blk   = m_asleep || (m_wake > 0);
      n_s2v = s1v && (s1l == 0) && !m_asleep;
      if (n_s2v) begin s2d = mem_m[s1a]; s2k = known[s1a]; end
      if (s1v && !m_asleep)
        for (int i = 0; i < 4; i++)
          if (s1l[i]) begin mem_m[s1a][9*i +: 9] = s1d[9*i +: 9]; known[s1a][i] = 1'b1; end
      s2v = n_s2v;
      n_v = 0; n_l = '0; n_a = addr;
      if (!blk) begin
        sel = !sel_a_n && sel_b && !sel_c_n;
        ps  = !cpu_n && !sel_a_n;
        cs  = !ctl_n;
        wl  = !wr_all_n ? 4'hF : (!lane_wr_n ? ~lane_en_n : 4'h0);
        if (ps || cs) begin
          n_v = sel; n_l = ps ? 4'h0 : wl;
          m_act = sel; m_base = addr; m_beat = 0;
        end else if (m_act) begin
          if (!step_n) m_beat = (m_beat + 1) % 4;
          lo  = linear ? 2'(m_base[1:0] + m_beat) : (m_base[1:0] ^ 2'(m_beat));
          n_a = {m_base[7:2], lo};
          n_v = 1; n_l = wl;
        end
      end
      if (m_asleep) m_act = 0;
      s1v = n_v; s1l = n_l; s1a = n_a; s1d = wdata;
      if (m_asleep) begin
        if (!sleep) begin m_asleep = 0; m_wake = 2; end
      end else if (m_wake > 0) m_wake--;
      else if (sleep) begin
        if (m_ent == 1) begin m_asleep = 1; m_ent = 0; end else m_ent++;
      end else m_ent = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual oe/data=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic compare();
    bit          e_oe;
    logic [35:0] m;
    e_oe = s2v && !oe_n && !m_asleep;
    for (int i = 0; i < 4; i++) m[9*i +: 9] = {9{s2k[i]}};
    if (e_oe)
      chk(rdata_oe && ((rdata & m) == (s2d & m)), cur_req, {rdata_oe, rdata}, {1'b1, s2d & m});
    else
      chk(!rdata_oe && rdata == '0, cur_req, {rdata_oe, rdata}, 37'h0);
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_in();
    sel_a_n = 1; sel_b = 0; sel_c_n = 1; cpu_n = 1; ctl_n = 1; step_n = 1;
    wr_all_n = 1; lane_wr_n = 1; lane_en_n = 4'hF; addr = '0; wdata = '0;
  endtask

  task automatic sel_on();
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
  endtask

  task automatic go(input bit cpu, input logic [7:0] a, input bit wr, input logic [35:0] d);
    sel_on();
    if (cpu) cpu_n = 0; else ctl_n = 0;
    addr = a; wr_all_n = !wr; wdata = d;
    tick();
    idle_in();
  endtask

  task automatic nxt(input bit wr, input logic [35:0] d);
    step_n = 0; wr_all_n = !wr; wdata = d;
    tick();
    step_n = 1; wr_all_n = 1; wdata = '0;
  endtask

  task automatic stop();
    ctl_n = 0; sel_a_n = 1;
    tick();
    ctl_n = 1;
    tick(); tick();
  endtask

  task automatic lane_wr(input logic [7:0] a, input bit lw_n, input logic [3:0] en_n, input logic [35:0] d);
    sel_on(); ctl_n = 0; addr = a; lane_wr_n = lw_n; lane_en_n = en_n; wdata = d;
    tick();
    idle_in();
    stop();
  endtask

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    idle_in();
    cur_req = "R7";
    repeat (3) tick();
    rst_n = 1;
    tick(); tick();

    // R4: full-word writes, linear burst 10..13
    cur_req = "R4"; linear = 1;
    go(0, 8'h10, 1, 36'hA00000000);
    nxt(1, 36'hA11111111); nxt(1, 36'hA22222222); nxt(1, 36'hA33333333);
    stop();

    // R9: linear read from offset 2, then interleaved write and read
    cur_req = "R9";
    go(1, 8'h12, 0, '0);
    nxt(0, '0); nxt(0, '0); nxt(0, '0); nxt(0, '0);
    stop();
    linear = 0;
    go(0, 8'h21, 1, 36'hB00000001);
    nxt(1, 36'hB00000002); nxt(1, 36'hB00000003); nxt(1, 36'hB00000004);
    stop();
    go(0, 8'h23, 0, '0);
    nxt(0, '0); nxt(0, '0); nxt(0, '0); nxt(0, '0);
    stop();
    linear = 1;

    // R10: suspend holds the address
    cur_req = "R10";
    go(0, 8'h10, 0, '0);
    tick(); tick();
    nxt(0, '0);
    tick(); tick();
    stop();

    // R3: host strobe with write controls is a read
    cur_req = "R3";
    sel_on(); cpu_n = 0; ctl_n = 0; addr = 8'h10; wr_all_n = 0; wdata = 36'hDEADBEEF0;
    tick(); idle_in(); tick(); tick();
    stop();
    go(0, 8'h10, 0, '0); tick(); tick();
    stop();

    // R5: lane writes and read fall-backs
    cur_req = "R5";
    lane_wr(8'h11, 0, 4'b1110, 36'h0000001FF);
    lane_wr(8'h12, 0, 4'b0101, 36'hFFFFFFFFF);
    lane_wr(8'h13, 0, 4'b1111, 36'h123456789);
    lane_wr(8'h13, 1, 4'b0000, 36'h123456789);
    go(0, 8'h10, 0, '0);
    nxt(0, '0); nxt(0, '0); nxt(0, '0); tick(); tick();
    stop();

    // R1: wrong selects
    cur_req = "R1";
    sel_on(); sel_b = 0; ctl_n = 0; addr = 8'h10;
    tick(); idle_in();
    step_n = 0; tick(); tick(); tick(); step_n = 1;
    sel_on(); sel_c_n = 1; cpu_n = 0; addr = 8'h11;
    tick(); idle_in(); tick(); tick();
    sel_on(); sel_c_n = 1; ctl_n = 0; addr = 8'h10; wr_all_n = 0; wdata = 36'hBADBADBAD;
    tick(); idle_in(); tick(); tick();
    go(0, 8'h10, 0, '0); tick(); tick();
    stop();

    // R2: host strobe ignored while select A is high
    cur_req = "R2";
    go(0, 8'h20, 0, '0);
    cpu_n = 0; sel_a_n = 1; step_n = 0; addr = 8'h00;
    tick(); cpu_n = 1; step_n = 1;
    tick(); tick();
    ctl_n = 0; sel_a_n = 1;
    tick(); ctl_n = 1;
    tick(); tick(); tick();

    // R6: read data latency
    cur_req = "R6";
    go(0, 8'h12, 0, '0);
    tick(); tick();

    // R8: asynchronous output enable
    cur_req = "R8";
    #1 oe_n = 1;
    #1 chk(rdata_oe == 0 && rdata == '0, "R8", {rdata_oe, rdata}, 37'h0);
    oe_n = 0;
    #1 chk(rdata_oe == 1 && rdata == s2d, "R8", {rdata_oe, rdata}, {1'b1, s2d});
    tick();
    oe_n = 1; tick(); tick(); oe_n = 0;
    tick();
    stop();

    // R11: sleep entry with a held read, writes refused while asleep
    cur_req = "R11";
    go(0, 8'h11, 0, '0);
    tick();
    sleep = 1;
    tick(); tick(); tick();
    chk(rdata_oe == 0, "R11", {rdata_oe, rdata}, 37'h0);
    sel_on(); ctl_n = 0; addr = 8'h10; wr_all_n = 0; wdata = 36'h0BADF00D1;
    tick(); idle_in(); tick(); tick();

    // R12: recovery edges still refuse strobes
    cur_req = "R12";
    sleep = 0;
    tick();
    sel_on(); ctl_n = 0; addr = 8'h11; wr_all_n = 0; wdata = 36'h0BADF00D2;
    tick(); tick();
    idle_in(); tick();
    go(0, 8'h10, 0, '0);
    nxt(0, '0); tick(); tick();
    stop();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule